// File: doc/BRIEF.md
# CAN Bit Timing Segment Generator

This block splits every nominal CAN bit into time quanta and marks the points of interest inside it. A time-quantum enable (`tq_en`), one clock wide and produced elsewhere, steps an in-bit quantum counter. Each bit has three parts: a one-quantum synchronisation segment, where bus edges are expected, then phase segment 1, then phase segment 2. The lengths of the two phase segments come from two small configuration fields, each holding the length minus one.

At the first quantum of a bit the block strobes the transmit point, so the transmitter can drive its next bit value. At the last quantum of segment 1 it strobes the sample point and updates the received bit. In single-sample mode the received bit is the line value at that quantum. In triple-sample mode it is the majority of that value and the line values at the two quanta before it, so the sample point is where the third sample is taken. A bit-end pulse marks the last quantum of every bit. Both configuration fields are captured at the start of each bit, so software may rewrite them at any time without corrupting the bit in progress. Timing runs freely from reset, and no resynchronisation is performed.

Top module: `can_bit_timer`

## Requirements
- R1: While `rst` is high and on the first clock after it, `tx_point`, `smp_point` and `bit_done` are 0 and `rx_bit` is 1. The quantum counter is at the sync quantum (index 0).
- R2: A bit lasts 3 + S1 + S2 quanta, where S1 is the value of `seg1_len_m1` (0..15) and S2 is the value of `seg2_len_m1` (0..7). `bit_done` pulses for the last quantum of each bit (index 2 + S1 + S2).
- R3: `tx_point` pulses for the sync quantum (index 0) of every bit, so the first `tq_en` after reset starts a bit.
- R4: `smp_point` pulses for the quantum at index S1 + 1, which is the last quantum of segment 1.
- R5: With `triple_smp` = 0, `rx_bit` takes the value of `rx_in` from the `tq_en` cycle of the sample quantum.
- R6: With `triple_smp` = 1, `rx_bit` takes the majority of `rx_in` at the sample quantum and at the two `tq_en` cycles before it, even where those lie in the sync quantum or the previous bit.
- R7: `rx_bit` changes only in the cycle in which `smp_point` is high.
- R8: S1 and S2 are captured at the sync quantum. A change of either field later in the bit has no effect until the next bit starts.
- R9: While `tq_en` is low the counter does not move and no strobe is raised.
- R10: Every strobe is registered and appears on the clock after the `tq_en` cycle it belongs to, one clock wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tq_en | input | 1 | Time-quantum enable, one clock per quantum |
| seg1_len_m1 | input | 4 | Phase segment 1 length minus one |
| seg2_len_m1 | input | 3 | Phase segment 2 length minus one |
| triple_smp | input | 1 | 1 selects majority-of-three sampling |
| rx_in | input | 1 | Raw receive line |
| tx_point | output | 1 | Transmit-point strobe (start of bit) |
| smp_point | output | 1 | Sample-point strobe |
| rx_bit | output | 1 | Sampled bit value |
| bit_done | output | 1 | Pulse on the last quantum of a bit |

## Verification
If the quantum counter or the captured segment lengths hold a wrong value, the strobes move. The error shows within one bit, at most 25 quanta: the spacing between `tx_point`, `smp_point` and `bit_done` no longer matches 3 + S1 + S2. If the sample history holds stale line values, the fault only shows when three-sample mode is active and the earlier samples disagree with the current one. The bench therefore drives random line values together with random timing settings that change in mid-bit. It compares all four outputs on every clock, so a fault is seen one clock after the quantum where it occurs.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int SEG1_W = 4;
  localparam int SEG2_W = 3;
  // highest quantum index in a bit: sync + longest seg1 + longest seg2 - 1
  localparam int LAST_MAX = (1 << SEG1_W) + (1 << SEG2_W);
  localparam int CNT_W = $clog2(LAST_MAX + 1);

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/can_bt_qcounter.sv
module can_bt_qcounter
  import can_bt_pkg::*;
#(
  parameter int S1W = SEG1_W,
  parameter int S2W = SEG2_W,
  parameter int CW  = CNT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tq_en,
  input  logic [S1W-1:0] seg1_cfg,
  input  logic [S2W-1:0] seg2_cfg,
  output logic           ev_start,
  output logic           ev_sample,
  output logic           ev_last
);
  logic [CW-1:0]  q_idx;
  logic [S1W-1:0] s1_lat;
  logic [S2W-1:0] s2_lat;
  logic [CW-1:0]  smp_idx;
  logic [CW-1:0]  last_idx;

  // sample quantum and last quantum, from the lengths captured for this bit
  assign smp_idx  = CW'(s1_lat) + CW'(1);
  assign last_idx = CW'(s1_lat) + CW'(s2_lat) + CW'(2);

  assign ev_start  = tq_en && (q_idx == '0);
  assign ev_sample = tq_en && (q_idx != '0) && (q_idx == smp_idx);
  assign ev_last   = tq_en && (q_idx != '0) && (q_idx == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_idx  <= '0;
      s1_lat <= '0;
      s2_lat <= '0;
    end else if (tq_en) begin
      if (q_idx == '0) begin
        s1_lat <= seg1_cfg;
        s2_lat <= seg2_cfg;
        q_idx  <= CW'(1);
      end else if (q_idx == last_idx) begin
        q_idx <= '0;
      end else begin
        q_idx <= q_idx + CW'(1);
      end
    end
  end

  // R2: the counter never runs past the last quantum of the current bit
  a_r2_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    (q_idx == '0) || (q_idx <= last_idx));
  // R2: the last quantum is followed by the sync quantum
  a_r2_wrap_to_sync: assert property (@(posedge clk) disable iff (rst)
    ev_last |=> (q_idx == '0));
  // R9: without a quantum enable the counter holds
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !tq_en |=> $stable(q_idx));
  // R8: captured lengths change only on a bit start
  a_r8_lat_stable: assert property (@(posedge clk) disable iff (rst)
    !ev_start |=> ($stable(s1_lat) && $stable(s2_lat)));
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tq_en,
  input  logic ev_sample,
  input  logic triple,
  input  logic rx_in,
  output logic rx_bit
);
  logic [1:0] hist;   // [0] previous quantum, [1] two quanta back
  logic       smp_val;

  assign smp_val = triple ? maj3(rx_in, hist[0], hist[1]) : rx_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= 2'b11;
      rx_bit <= 1'b1;
    end else if (tq_en) begin
      hist <= {hist[0], rx_in};
      if (ev_sample) rx_bit <= smp_val;
    end
  end

  // R7: the received bit moves only when a sample is taken
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (rst)
    !ev_sample |=> $stable(rx_bit));
  // R6: three agreeing line values always win
  a_r6_unanimous: assert property (@(posedge clk) disable iff (rst)
    (ev_sample && triple && rx_in && hist == 2'b11) |=> rx_bit);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tq_en,
  input  logic [SEG1_W-1:0] seg1_len_m1,
  input  logic [SEG2_W-1:0] seg2_len_m1,
  input  logic              triple_smp,
  input  logic              rx_in,
  output logic              tx_point,
  output logic              smp_point,
  output logic              rx_bit,
  output logic              bit_done
);
  logic ev_start, ev_sample, ev_last;

  can_bt_qcounter #(.S1W(SEG1_W), .S2W(SEG2_W), .CW(CNT_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .tq_en    (tq_en),
    .seg1_cfg (seg1_len_m1),
    .seg2_cfg (seg2_len_m1),
    .ev_start (ev_start),
    .ev_sample(ev_sample),
    .ev_last  (ev_last)
  );

  can_bt_sampler smp_i (
    .clk      (clk),
    .rst      (rst),
    .tq_en    (tq_en),
    .ev_sample(ev_sample),
    .triple   (triple_smp),
    .rx_in    (rx_in),
    .rx_bit   (rx_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_point  <= 1'b0;
      smp_point <= 1'b0;
      bit_done  <= 1'b0;
    end else begin
      tx_point  <= ev_start;
      smp_point <= ev_sample;
      bit_done  <= ev_last;
    end
  end

  // R10: strobes belong to a quantum enable one clock earlier
  a_r10_strobe_after_tq: assert property (@(posedge clk) disable iff (rst)
    (tx_point || smp_point || bit_done) |-> $past(tq_en));
  // R10: strobes are single clocks wide
  a_r10_tx_single: assert property (@(posedge clk) disable iff (rst)
    tx_point |=> !tx_point);
  a_r10_smp_single: assert property (@(posedge clk) disable iff (rst)
    smp_point |=> !smp_point);
  // R4: the sample point never coincides with the sync quantum
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(tx_point && smp_point));
  // R7: received bit is steady outside sample strobes
  a_r7_rx_port_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_point |-> $stable(rx_bit));
endmodule

// File: tb/can_bit_timer_tb_top.sv
module can_bit_timer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tq_en = 1'b0;
  logic [3:0] seg1 = 4'd0;
  logic [2:0] seg2 = 3'd0;
  logic triple = 1'b0;
  logic rx_in = 1'b1;
  logic tx_point, smp_point, rx_bit, bit_done;

  int n_checks = 0;
  int n_fail = 0;

  // model state
  int m_q = 0, m_s1 = 0, m_s2 = 0;
  logic [1:0] m_hist = 2'b11;
  logic e_tx = 0, e_smp = 0, e_done = 0, e_rx = 1;

  always #2.5 clk = ~clk;

  can_bit_timer dut_i (
    .clk(clk), .rst(rst), .tq_en(tq_en), .seg1_len_m1(seg1),
    .seg2_len_m1(seg2), .triple_smp(triple), .rx_in(rx_in),
    .tx_point(tx_point), .smp_point(smp_point), .rx_bit(rx_bit),
    .bit_done(bit_done)
  );

  function automatic logic maj(input logic a, input logic b, input logic c);
    return (a + b + c) >= 2;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // model of one clock edge, written from the requirements
  task automatic model_step();
    e_tx = 0; e_smp = 0; e_done = 0;
    if (rst) begin
      m_q = 0; m_s1 = 0; m_s2 = 0; m_hist = 2'b11; e_rx = 1;
    end else if (tq_en) begin
      if (m_q == 0) begin
        m_s1 = seg1; m_s2 = seg2; e_tx = 1; m_q = 1;
      end else begin
        if (m_q == m_s1 + 1) begin
          e_smp = 1;
          e_rx = triple ? maj(rx_in, m_hist[0], m_hist[1]) : rx_in;
        end
        if (m_q == m_s1 + m_s2 + 2) begin e_done = 1; m_q = 0; end
        else m_q = m_q + 1;
      end
      m_hist = {m_hist[0], rx_in};
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R3 tx_point", tx_point, e_tx);
    check("R4 smp_point", smp_point, e_smp);
    check("R2 bit_done", bit_done, e_done);
    check(triple ? "R6 rx_bit" : "R5 rx_bit", rx_bit, e_rx);
  endtask

  // R2: clocks between bit_done pulses with tq_en held high
  task automatic measure_len(input int s1, input int s2);
    int gap;
    seg1 = 4'(s1); seg2 = 3'(s2); tq_en = 1;
    for (int k = 0; k < 2; k++) begin
      gap = 0;
      do begin tick(); gap++; end while (!bit_done);
    end
    check("R2 bit length", gap == 3 + s1 + s2, 1'b1);
  endtask

  initial begin
    #1000000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    for (int i = 0; i < 3; i++) tick();
    check("R1 tx_point", tx_point, 1'b0);
    check("R1 smp_point", smp_point, 1'b0);
    check("R1 bit_done", bit_done, 1'b0);
    check("R1 rx_bit", rx_bit, 1'b1);
    rst = 0;
    tick();
    check("R1 first clock", tx_point | smp_point | bit_done, 1'b0);

    // R3: first quantum enable starts a bit
    tq_en = 1; seg1 = 4'd2; seg2 = 3'd1;
    tick();
    check("R3 first bit", tx_point, 1'b1);

    // R2: extreme lengths
    measure_len(15, 7);
    measure_len(0, 0);
    measure_len(5, 3);

    // R6: triple mode with shortest seg1, earlier samples from sync and previous bit
    triple = 1; seg1 = 4'd0; seg2 = 3'd0;
    for (int i = 0; i < 40; i++) begin rx_in = 1'($urandom); tick(); end

    // R9: no advance without tq_en
    tq_en = 0;
    for (int i = 0; i < 20; i++) begin
      rx_in = 1'($urandom); tick();
      check("R9 idle strobes", tx_point | smp_point | bit_done, 1'b0);
    end

    // R8: config changes in mid-bit, directed
    tq_en = 1; seg1 = 4'd3; seg2 = 3'd2;
    do tick(); while (!tx_point);
    seg1 = 4'd10; seg2 = 3'd6;
    begin
      int gap = 1;
      while (!bit_done) begin tick(); gap++; end
      check("R8 current bit kept", gap == 3 + 3 + 2, 1'b1);
    end

    // random phase: R5, R6, R7, R8, R10 via model comparison
    for (int i = 0; i < 30000; i++) begin
      tq_en = ($urandom_range(3) != 0);
      rx_in = 1'($urandom);
      if ($urandom_range(15) == 0) seg1 = 4'($urandom);
      if ($urandom_range(15) == 0) seg2 = 3'($urandom);
      if ($urandom_range(63) == 0) triple = ~triple;
      tick();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule